// File: doc/BRIEF.md
# Interrupt Request Destination Router

This block takes rising edges from a small set of interrupt sources and sends each one to one of three places: the processor interrupt line, the activation port of a data transfer controller, or the activation port of a DMA controller. Each source has a 2-bit destination field. A bus write sets the field, and a read port returns its current value. A detected edge sets a pending flag. The flag stays set until the destination that received it acknowledges it.

The transfer controller reports back through a completion interface. That interface carries a source index, a done strobe, a counter-zero flag and a one-shot (chain-disable) bit. When a transfer finishes, the hardware rewrites the source's field to the CPU code and raises the processor interrupt. In this way a transfer trigger turns into an interrupt once the data has moved. Software can set the field back to the transfer code later. The transfer controller then starts again only on a fresh request edge.

Top module: `irq_route_top`

## Requirements
- R1: After reset every destination field reads 00, and `cpu_irq`, `xfer_req` and `dma_req` are all low.
- R2: Field code 00 routes a source. A rising edge on that source sets `cpu_irq` one clock later, and raises neither `xfer_req` nor `dma_req`.
- R3: Field code 01 routes a source. Its edge raises `xfer_req[i]` one clock later and leaves `cpu_irq` low.
- R4: Field code 10 routes a source. Its edge raises `dma_req[i]` only. After `dma_ack[i]` the field still reads 10.
- R5: Field code 11 routes a source. Its edge raises both `dma_req[i]` and `cpu_irq` one clock later.
- R6: A completion for a source at code 01 has one-shot 0. If counter-zero is 0, the field stays 01 and `cpu_irq` stays low. If counter-zero is 1, the field becomes 00 and `cpu_irq` rises on the next clock.
- R7: A completion for a source at code 01 has one-shot 1. The field becomes 00 and `cpu_irq` rises, whatever the counter-zero flag is.
- R8: A completion naming a source whose field is not 01 changes neither the field nor `cpu_irq`.
- R9: A hardware rewrite on a completion takes priority over a bus write to the same source in the same cycle. A write to another source in that cycle still takes effect.
- R10: `cpu_ack` with `cpu_ack_idx` clears only that source's CPU pending flag. `xfer_ack[i]` or `dma_ack[i]` clears the transfer request of source i. A new edge in the same cycle as an acknowledge wins.
- R11: A source held high gives exactly one request. After software writes the field back to 01, no transfer request appears until the source falls and rises again.
- R12: `cfg_rd_data` shows the field selected by `cfg_rd_idx` combinationally, and a bus write is visible there from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Source request lines, rising edge detected |
| cfg_wr_en | input | 1 | Bus write strobe for a destination field |
| cfg_wr_idx | input | IDX_W | Source whose field is written |
| cfg_wr_data | input | 2 | New destination code |
| cfg_rd_idx | input | IDX_W | Source whose field is read |
| cfg_rd_data | output | 2 | Current destination code of the read source |
| cmp_done | input | 1 | Transfer controller completion strobe |
| cmp_idx | input | IDX_W | Source the completion refers to |
| cmp_cnt_zero | input | 1 | Transfer counter reached zero |
| cmp_one_shot | input | 1 | Chain-disable bit of the finished transfer |
| cpu_ack | input | 1 | Processor acknowledge strobe |
| cpu_ack_idx | input | IDX_W | Source the processor acknowledges |
| xfer_ack | input | NUM_SRC | Transfer controller accepted the request |
| dma_ack | input | NUM_SRC | DMA controller accepted the request |
| cpu_irq | output | 1 | Processor interrupt, OR of CPU pending flags |
| xfer_req | output | NUM_SRC | Transfer controller activation per source |
| dma_req | output | NUM_SRC | DMA controller activation per source |

## Verification
The assertions assume that every index on the write, completion and acknowledge paths names an existing source. They also assume that the source lines are synchronous to `clk`, so that the registered edge detector sees each level for at least one cycle. The default configuration has four sources and 2-bit indices, so every index the bench can drive is legal. The directed steps and the random phase change source levels only between clock edges, and each change lasts at least one cycle. The random phase also lands acknowledges, completions and writes on the same source in the same cycle, which exercises the priority rules.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    DST_CPU     = 2'b00,
    DST_XFER    = 2'b01,
    DST_DMA     = 2'b10,
    DST_DMA_CPU = 2'b11
  } dest_e;

  // Code sends a pending flag to the processor line on an edge
  function automatic logic dest_to_cpu(input logic [1:0] code);
    return (code == DST_CPU) || (code == DST_DMA_CPU);
  endfunction

  // Code activates the transfer controller
  function automatic logic dest_to_xfer(input logic [1:0] code);
    return code == DST_XFER;
  endfunction

  // Code activates the DMA controller (with or without the processor)
  function automatic logic dest_to_dma(input logic [1:0] code);
    return code[1];
  endfunction

  // Completion turns the transfer trigger into a processor interrupt
  function automatic logic xfer_finished(input logic [1:0] code,
                                         input logic       done,
                                         input logic       cnt_zero,
                                         input logic       one_shot);
    return done && (code == DST_XFER) && (cnt_zero || one_shot);
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] src_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[i] <= 1'b0;
      else        src_q[i] <= src_i[i];
    end
    assign rise_o[i] = src_i[i] & ~src_q[i];
  end

endmodule

// File: rtl/irq_sel_bank.sv
module irq_sel_bank #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [1:0]              wr_data,
  input  logic [NUM_SRC-1:0]      hw_clr,
  output logic [NUM_SRC-1:0][1:0] sel_o,
  output logic [NUM_SRC-1:0]      wr_hit_o
);
  import irq_route_pkg::*;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
    assign wr_hit_o[i] = wr_en && (wr_idx == IDX_W'(i));

    // Hardware rewrite outranks a bus write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sel_o[i] <= DST_CPU;
      else if (hw_clr[i])   sel_o[i] <= DST_CPU;
      else if (wr_hit_o[i]) sel_o[i] <= wr_data;
    end
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      rise_i,
  input  logic [NUM_SRC-1:0][1:0] sel_i,
  input  logic [NUM_SRC-1:0]      hw_clr,
  input  logic                    cpu_ack,
  input  logic [IDX_W-1:0]        cpu_ack_idx,
  input  logic [NUM_SRC-1:0]      xfer_ack,
  input  logic [NUM_SRC-1:0]      dma_ack,
  output logic [NUM_SRC-1:0]      pend_cpu_o,
  output logic [NUM_SRC-1:0]      pend_xfer_o
);
  import irq_route_pkg::*;

  logic [NUM_SRC-1:0] set_cpu, clr_cpu, set_xfer, clr_xfer;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    assign set_cpu[i]  = (rise_i[i] && dest_to_cpu(sel_i[i])) || hw_clr[i];
    assign clr_cpu[i]  = cpu_ack && (cpu_ack_idx == IDX_W'(i));
    assign set_xfer[i] = rise_i[i] && (sel_i[i] != DST_CPU);
    assign clr_xfer[i] = xfer_ack[i] || dma_ack[i] || hw_clr[i];

    // A new request outranks an acknowledge in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_cpu_o[i]  <= 1'b0;
        pend_xfer_o[i] <= 1'b0;
      end else begin
        if (set_cpu[i])       pend_cpu_o[i] <= 1'b1;
        else if (clr_cpu[i])  pend_cpu_o[i] <= 1'b0;
        if (set_xfer[i])      pend_xfer_o[i] <= 1'b1;
        else if (clr_xfer[i]) pend_xfer_o[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               cfg_wr_en,
  input  logic [IDX_W-1:0]   cfg_wr_idx,
  input  logic [1:0]         cfg_wr_data,
  input  logic [IDX_W-1:0]   cfg_rd_idx,
  output logic [1:0]         cfg_rd_data,
  input  logic               cmp_done,
  input  logic [IDX_W-1:0]   cmp_idx,
  input  logic               cmp_cnt_zero,
  input  logic               cmp_one_shot,
  input  logic               cpu_ack,
  input  logic [IDX_W-1:0]   cpu_ack_idx,
  input  logic [NUM_SRC-1:0] xfer_ack,
  input  logic [NUM_SRC-1:0] dma_ack,
  output logic               cpu_irq,
  output logic [NUM_SRC-1:0] xfer_req,
  output logic [NUM_SRC-1:0] dma_req
);
  import irq_route_pkg::*;

  // Named internal events, also watched by the checker
  logic [NUM_SRC-1:0]      edge_evt;
  logic [NUM_SRC-1:0]      hw_clr;
  logic [NUM_SRC-1:0]      wr_hit;
  logic [NUM_SRC-1:0][1:0] sel;
  logic [NUM_SRC-1:0]      pend_cpu;
  logic [NUM_SRC-1:0]      pend_xfer;

  irq_edge_det #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_irq),
    .rise_o (edge_evt)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign hw_clr[i] = xfer_finished(sel[i], cmp_done && (cmp_idx == IDX_W'(i)),
                                     cmp_cnt_zero, cmp_one_shot);
  end

  irq_sel_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_idx   (cfg_wr_idx),
    .wr_data  (cfg_wr_data),
    .hw_clr   (hw_clr),
    .sel_o    (sel),
    .wr_hit_o (wr_hit)
  );

  irq_pend_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (edge_evt),
    .sel_i       (sel),
    .hw_clr      (hw_clr),
    .cpu_ack     (cpu_ack),
    .cpu_ack_idx (cpu_ack_idx),
    .xfer_ack    (xfer_ack),
    .dma_ack     (dma_ack),
    .pend_cpu_o  (pend_cpu),
    .pend_xfer_o (pend_xfer)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_out
    assign xfer_req[i] = pend_xfer[i] && dest_to_xfer(sel[i]);
    assign dma_req[i]  = pend_xfer[i] && dest_to_dma(sel[i]);
  end

  assign cpu_irq = |pend_cpu;

  always_comb begin
    cfg_rd_data = DST_CPU;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfg_rd_idx == IDX_W'(i)) cfg_rd_data = sel[i];
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_SRC-1:0][1:0] sel,
  input logic [NUM_SRC-1:0]      edge_evt,
  input logic [NUM_SRC-1:0]      hw_clr,
  input logic [NUM_SRC-1:0]      wr_hit,
  input logic                    cmp_done,
  input logic [IDX_W-1:0]        cmp_idx,
  input logic                    cmp_cnt_zero,
  input logic                    cmp_one_shot,
  input logic [NUM_SRC-1:0]      dma_ack,
  input logic                    cpu_irq,
  input logic [NUM_SRC-1:0]      xfer_req,
  input logic [NUM_SRC-1:0]      dma_req
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    p_edge_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] && sel[i] == 2'b00 |=> cpu_irq);

    p_edge_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] && sel[i] == 2'b01 && !wr_hit[i] && !hw_clr[i] |=> xfer_req[i]);

    p_dma_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel[i] == 2'b10 && dma_ack[i] && !wr_hit[i] |=> sel[i] == 2'b10);

    p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] && sel[i] == 2'b11 && !wr_hit[i] |=> cpu_irq && dma_req[i]);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done && cmp_idx == IDX_W'(i) && sel[i] == 2'b01 && !cmp_cnt_zero
        && !cmp_one_shot && !wr_hit[i] |=> sel[i] == 2'b01);

    p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done && cmp_idx == IDX_W'(i) && sel[i] == 2'b01 && cmp_one_shot
        |=> sel[i] == 2'b00 && cpu_irq);

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done && cmp_idx == IDX_W'(i) && sel[i] != 2'b01 && !wr_hit[i]
        |=> $stable(sel[i]));

    p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr[i] && wr_hit[i] |=> sel[i] == 2'b00);
  end

endmodule

bind irq_route_top irq_route_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel          (sel),
  .edge_evt     (edge_evt),
  .hw_clr       (hw_clr),
  .wr_hit       (wr_hit),
  .cmp_done     (cmp_done),
  .cmp_idx      (cmp_idx),
  .cmp_cnt_zero (cmp_cnt_zero),
  .cmp_one_shot (cmp_one_shot),
  .dma_ack      (dma_ack),
  .cpu_irq      (cpu_irq),
  .xfer_req     (xfer_req),
  .dma_req      (dma_req)
);

// File: tb/test_irq_route_top.sv
`timescale 1ns/1ps
module test_irq_route_top;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_irq = '0;
  logic         cfg_wr_en = 1'b0;
  logic [W-1:0] cfg_wr_idx = '0;
  logic [1:0]   cfg_wr_data = '0;
  logic [W-1:0] cfg_rd_idx = '0;
  logic [1:0]   cfg_rd_data;
  logic         cmp_done = 1'b0;
  logic [W-1:0] cmp_idx = '0;
  logic         cmp_cnt_zero = 1'b0;
  logic         cmp_one_shot = 1'b0;
  logic         cpu_ack = 1'b0;
  logic [W-1:0] cpu_ack_idx = '0;
  logic [N-1:0] xfer_ack = '0;
  logic [N-1:0] dma_ack = '0;
  logic         cpu_irq;
  logic [N-1:0] xfer_req;
  logic [N-1:0] dma_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_route_top #(.NUM_SRC(N)) i_irq_route_top (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .cmp_done(cmp_done), .cmp_idx(cmp_idx), .cmp_cnt_zero(cmp_cnt_zero),
    .cmp_one_shot(cmp_one_shot), .cpu_ack(cpu_ack), .cpu_ack_idx(cpu_ack_idx),
    .xfer_ack(xfer_ack), .dma_ack(dma_ack),
    .cpu_irq(cpu_irq), .xfer_req(xfer_req), .dma_req(dma_req)
  );

  // Behavioural reference: per-source state held in plain integer arrays
  int m_code [N];
  int m_cpu  [N];
  int m_xfr  [N];
  int m_prev [N];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_code[i] = 0; m_cpu[i] = 0; m_xfr[i] = 0; m_prev[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        int  code;
        bit  rose, fin;
        code = m_code[i];
        rose = src_irq[i] && m_prev[i] == 0;
        fin  = cmp_done && int'(cmp_idx) == i && code == 1 && (cmp_cnt_zero || cmp_one_shot);
        if (fin) m_code[i] = 0;
        else if (cfg_wr_en && int'(cfg_wr_idx) == i) m_code[i] = int'(cfg_wr_data);
        if ((rose && (code == 0 || code == 3)) || fin) m_cpu[i] = 1;
        else if (cpu_ack && int'(cpu_ack_idx) == i) m_cpu[i] = 0;
        if (rose && code != 0) m_xfr[i] = 1;
        else if (xfer_ack[i] || dma_ack[i] || fin) m_xfr[i] = 0;
        m_prev[i] = src_irq[i] ? 1 : 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ecpu;
      ecpu = 0;
      for (int i = 0; i < N; i++) begin
        if (m_cpu[i] != 0) ecpu = 1;
        chk("R3 xfer_req model", int'(xfer_req[i]), (m_xfr[i] != 0 && m_code[i] == 1) ? 1 : 0);
        chk("R4 dma_req model", int'(dma_req[i]), (m_xfr[i] != 0 && m_code[i] >= 2) ? 1 : 0);
      end
      chk("R2 cpu_irq model", int'(cpu_irq), ecpu);
      chk("R12 readback model", int'(cfg_rd_data), m_code[int'(cfg_rd_idx)]);
    end
  end

  // One clock: stimulus set before the call is consumed, strobes then drop
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    cfg_wr_en = 0; cmp_done = 0; cpu_ack = 0; xfer_ack = '0; dma_ack = '0;
  endtask

  task automatic wr(input int idx, input int code);
    cfg_wr_en = 1; cfg_wr_idx = W'(idx); cfg_wr_data = 2'(code);
    tick();
  endtask

  function automatic int rd(input int idx);
    return 0;
  endfunction

  task automatic read_field(input int idx, output int val);
    cfg_rd_idx = W'(idx);
    #0.5;
    val = int'(cfg_rd_data);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1;
    // R1: reset state
    for (int i = 0; i < N; i++) begin
      read_field(i, v); chk("R1 field after reset", v, 0);
    end
    chk("R1 cpu_irq after reset", int'(cpu_irq), 0);
    chk("R1 xfer_req after reset", int'(xfer_req), 0);
    chk("R1 dma_req after reset", int'(dma_req), 0);

    // R12: write then read back
    wr(1, 1);
    read_field(1, v); chk("R12 readback of written field", v, 1);

    // R2: code 00 goes to the processor
    src_irq[0] = 1; tick();
    chk("R2 cpu_irq after edge", int'(cpu_irq), 1);
    chk("R2 no xfer_req", int'(xfer_req[0]), 0);
    chk("R2 no dma_req", int'(dma_req[0]), 0);
    // R10: wrong index keeps it, right index clears
    cpu_ack = 1; cpu_ack_idx = 2; tick();
    chk("R10 ack of other source keeps cpu_irq", int'(cpu_irq), 1);
    cpu_ack = 1; cpu_ack_idx = 0; tick();
    chk("R10 ack clears cpu_irq", int'(cpu_irq), 0);
    tick();
    chk("R11 held level gives no second request", int'(cpu_irq), 0);
    src_irq[0] = 0; tick();

    // R3: code 01 goes to the transfer controller
    src_irq[1] = 1; tick();
    chk("R3 xfer_req after edge", int'(xfer_req[1]), 1);
    chk("R3 cpu_irq stays low", int'(cpu_irq), 0);
    xfer_ack[1] = 1; tick();
    chk("R10 xfer_ack clears request", int'(xfer_req[1]), 0);
    // R6: not yet finished
    cmp_done = 1; cmp_idx = 1; cmp_cnt_zero = 0; cmp_one_shot = 0; tick();
    read_field(1, v); chk("R6 field holds 01 before count end", v, 1);
    chk("R6 no cpu_irq before count end", int'(cpu_irq), 0);
    cmp_done = 1; cmp_idx = 1; cmp_cnt_zero = 1; cmp_one_shot = 0; tick();
    read_field(1, v); chk("R6 field cleared at count end", v, 0);
    chk("R6 cpu_irq at count end", int'(cpu_irq), 1);
    cpu_ack = 1; cpu_ack_idx = 1; tick();
    // R11: rewrite to 01 while source still high
    wr(1, 1); tick();
    chk("R11 no transfer without new edge", int'(xfer_req[1]), 0);
    src_irq[1] = 0; tick();
    src_irq[1] = 1; tick();
    chk("R11 new edge restarts transfer", int'(xfer_req[1]), 1);
    xfer_ack[1] = 1; tick();
    // R7: one-shot completion regardless of counter
    cmp_done = 1; cmp_idx = 1; cmp_cnt_zero = 0; cmp_one_shot = 1; tick();
    read_field(1, v); chk("R7 one-shot clears field", v, 0);
    chk("R7 one-shot raises cpu_irq", int'(cpu_irq), 1);
    cpu_ack = 1; cpu_ack_idx = 1; tick();
    src_irq[1] = 0;

    // R4: code 10 to DMA only
    wr(2, 2);
    src_irq[2] = 1; tick();
    chk("R4 dma_req after edge", int'(dma_req[2]), 1);
    chk("R4 no cpu_irq", int'(cpu_irq), 0);
    dma_ack[2] = 1; tick();
    chk("R4 dma_ack clears request", int'(dma_req[2]), 0);
    read_field(2, v); chk("R4 field stays 10", v, 2);

    // R8: completion on a non-01 field ignored
    cmp_done = 1; cmp_idx = 2; cmp_cnt_zero = 1; cmp_one_shot = 1; tick();
    read_field(2, v); chk("R8 field unchanged", v, 2);
    chk("R8 cpu_irq unchanged", int'(cpu_irq), 0);

    // R5: code 11 to DMA and processor at once
    wr(3, 3);
    src_irq[3] = 1; tick();
    chk("R5 dma_req", int'(dma_req[3]), 1);
    chk("R5 cpu_irq", int'(cpu_irq), 1);
    dma_ack[3] = 1; cpu_ack = 1; cpu_ack_idx = 3; tick();
    chk("R10 both acks clear", int'(cpu_irq) + int'(dma_req[3]), 0);

    // R9: completion beats same-cycle write on same source
    wr(0, 1);
    src_irq[0] = 1; tick();
    xfer_ack[0] = 1; tick();
    cmp_done = 1; cmp_idx = 0; cmp_cnt_zero = 0; cmp_one_shot = 1;
    cfg_wr_en = 1; cfg_wr_idx = 0; cfg_wr_data = 2; tick();
    read_field(0, v); chk("R9 hardware rewrite wins", v, 0);
    cpu_ack = 1; cpu_ack_idx = 0; tick();
    wr(0, 1);
    cmp_done = 1; cmp_idx = 0; cmp_cnt_zero = 1; cmp_one_shot = 0;
    cfg_wr_en = 1; cfg_wr_idx = 1; cfg_wr_data = 3; tick();
    read_field(1, v); chk("R9 write to other source proceeds", v, 3);
    read_field(0, v); chk("R9 completed source cleared", v, 0);

    // Random phase checked by the reference every cycle
    for (int k = 0; k < 3000; k++) begin
      src_irq = N'($urandom);
      if ($urandom_range(3) == 0) begin
        cfg_wr_en = 1; cfg_wr_idx = W'($urandom); cfg_wr_data = 2'($urandom);
      end
      if ($urandom_range(3) == 0) begin
        cmp_done = 1; cmp_idx = W'($urandom);
        cmp_cnt_zero = 1'($urandom); cmp_one_shot = 1'($urandom);
      end
      if ($urandom_range(2) == 0) begin
        cpu_ack = 1; cpu_ack_idx = W'($urandom);
      end
      xfer_ack = N'($urandom) & N'($urandom);
      dma_ack  = N'($urandom) & N'($urandom);
      cfg_rd_idx = W'($urandom);
      tick();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule